// File: doc/BRIEF.md
# Capture Program and Video Stream Aligner

This block sits between a stream of capture instructions and a FIFO of tagged video words and keeps the two in step. A write instruction asks for a number of pixel words for the current line and may mark the line's last piece. A sync instruction names the end-of-field code it expects next. FIFO words are either pixel data or control tags for the end of a line or the end of an even or odd field.

Pixel words that match a write instruction are passed to a registered write port. When the stream and the program disagree about the length of a line or the number of lines in a field, the block recovers. It either skips instructions or pops and discards FIFO words until both sides reach the same boundary. Every recovery raises a sticky interrupt flag, which stays set until software clears it with a one-cycle pulse.

Top module: `capstream_resync`

## Requirements
- R1: After a synchronous reset, `wr_valid` and `irq_resync` are 0, `ins_ready` is 1 and `fifo_ready` is 0: the block waits for an instruction with no mismatch pending.
- R2: Instruction word layout is opcode in bits [16:15] (01 = sync, any other value = write), word count in [14:3], end-of-line flag in bit 2 and sync status in [1:0]. A write instruction with count N moves the next N FIFO words tagged 00 (data) to `wr_data`, in order. Each such write is issued one cycle after its FIFO pop.
- R3: FIFO tags are 00 data, 01 end of line, 10 end of even field and 11 end of odd field. If tag 01 arrives before the current write instruction has its count, and that instruction has no end-of-line flag, then the following instructions are accepted and dropped. This continues up to and including the next write with the end-of-line flag. No write is issued for them and the interrupt is set.
- R4: If a write instruction with the end-of-line flag has its full count and the FIFO then delivers data instead of tag 01, those words are popped and not written, and the interrupt is set. This goes on until tag 01 is popped.
- R5: If tag 10 or 11 is popped while a line is in progress, the interrupt is set. Instructions are then accepted and dropped until a sync instruction whose status matches that tag. Status 01 matches tag 10 and status 10 matches tag 11.
- R6: After a sync instruction, every FIFO word other than the matching end-of-field tag is popped and discarded, and the interrupt is set. The matching tag ends the wait.
- R7: A matching line end or a matching sync/end-of-field pair is consumed without a write and without touching the interrupt.
- R8: `irq_resync` stays 1 once set. A one-cycle pulse on `irq_clear` drops it in the following cycle, unless a new recovery happens in the same cycle.
- R9: While `wr_valid` is 1 and `wr_ready` is 0, `wr_valid` and `wr_data` hold. No data word is lost or duplicated under back-pressure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ins_valid | input | 1 | Instruction word offered |
| ins_ready | output | 1 | Instruction word accepted this cycle |
| ins_word | input | 17 | Instruction: opcode, count, end-of-line flag, sync status |
| fifo_valid | input | 1 | FIFO word offered |
| fifo_ready | output | 1 | FIFO word popped this cycle |
| fifo_data | input | 32 | FIFO payload |
| fifo_tag | input | 2 | FIFO word tag |
| wr_valid | output | 1 | Write port holds a pixel word |
| wr_ready | input | 1 | Write port sink accepts |
| wr_data | output | 32 | Pixel word to write |
| irq_clear | input | 1 | Write-one-to-clear for the interrupt |
| irq_resync | output | 1 | Sticky resynchronization interrupt |

## Verification
The properties assume that `ins_word`, `fifo_data` and `fifo_tag` are stable while their valid is high. They also assume that sync instructions carry only status 01 or 10, since only bit 1 of the status selects the field. The stimulus offers each instruction and FIFO word from a queue, holds it until the handshake completes and uses only those two status values. It toggles `wr_ready` in a fixed pattern so that stalls hit the output register mid-line.

// File: rtl/resync_pkg.sv
package resync_pkg;

  typedef enum logic [2:0] {
    ST_FETCH      = 3'd0,
    ST_XFER       = 3'd1,
    ST_EOL_WAIT   = 3'd2,
    ST_FIELD_WAIT = 3'd3,
    ST_SKIP_LINE  = 3'd4,
    ST_SKIP_FIELD = 3'd5
  } rs_state_t;

  localparam logic [1:0] TAG_DATA = 2'b00;
  localparam logic [1:0] TAG_EOL  = 2'b01;
  localparam logic [1:0] OP_SYNC  = 2'b01;

  // status 01 -> even end (tag 10), status 10 -> odd end (tag 11)
  function automatic logic [1:0] field_tag_of(input logic [1:0] status);
    return {1'b1, status[1]};
  endfunction

  function automatic logic is_field_end(input logic [1:0] tag);
    return tag[1];
  endfunction

endpackage

// File: rtl/resync_remain.sv
module resync_remain #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             last
);
  logic [CNT_W-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst)       left_q <= '0;
    else if (load) left_q <= load_val;
    else if (dec)  left_q <= left_q - 1'b1;
  end

  assign last = (left_q == CNT_W'(1));
endmodule

// File: rtl/resync_irq.sv
module resync_irq (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst)      flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end
endmodule

// File: rtl/resync_outreg.sv
module resync_outreg #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              free
);
  assign free = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst)       out_valid <= 1'b0;
    else if (free) out_valid <= push;
  end

  always_ff @(posedge clk) begin
    if (free && push) out_data <= push_data;
  end
endmodule

// File: rtl/capstream_resync.sv
module capstream_resync
  import resync_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 12,
  localparam int INS_W = CNT_W + 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ins_valid,
  output logic              ins_ready,
  input  logic [INS_W-1:0]  ins_word,
  input  logic              fifo_valid,
  output logic              fifo_ready,
  input  logic [DATA_W-1:0] fifo_data,
  input  logic [1:0]        fifo_tag,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [DATA_W-1:0] wr_data,
  input  logic              irq_clear,
  output logic              irq_resync
);
  localparam int OP_HI  = INS_W - 1;
  localparam int CNT_HI = INS_W - 3;

  rs_state_t state_q, state_d;
  logic      eol_q, eol_d;
  logic [1:0] exp_q, exp_d;

  logic [1:0]       in_op;
  logic [CNT_W-1:0] in_cnt;
  logic             in_eol, in_sync;
  logic [1:0]       in_tag;

  logic out_free, ins_fire, fifo_fire;
  logic push, cnt_load, cnt_dec, cnt_last, irq_set;

  assign in_op   = ins_word[OP_HI -: 2];
  assign in_cnt  = ins_word[CNT_HI -: CNT_W];
  assign in_eol  = ins_word[2];
  assign in_sync = (in_op == OP_SYNC);
  assign in_tag  = field_tag_of(ins_word[1:0]);

  assign ins_ready  = (state_q == ST_FETCH) || (state_q == ST_SKIP_LINE) ||
                      (state_q == ST_SKIP_FIELD);
  assign fifo_ready = ((state_q == ST_XFER) && out_free) ||
                      (state_q == ST_EOL_WAIT) || (state_q == ST_FIELD_WAIT);
  assign ins_fire   = ins_valid && ins_ready;
  assign fifo_fire  = fifo_valid && fifo_ready;

  always_comb begin
    state_d  = state_q;
    eol_d    = eol_q;
    exp_d    = exp_q;
    push     = 1'b0;
    cnt_load = 1'b0;
    cnt_dec  = 1'b0;
    irq_set  = 1'b0;
    unique case (state_q)
      ST_FETCH: if (ins_fire) begin
        if (in_sync) begin
          exp_d   = in_tag;
          state_d = ST_FIELD_WAIT;
        end else begin
          eol_d = in_eol;
          if (in_cnt != '0) begin
            cnt_load = 1'b1;
            state_d  = ST_XFER;
          end else begin
            state_d = in_eol ? ST_EOL_WAIT : ST_FETCH;
          end
        end
      end
      ST_XFER: if (fifo_fire) begin
        if (fifo_tag == TAG_DATA) begin
          push    = 1'b1;
          cnt_dec = 1'b1;
          if (cnt_last) state_d = eol_q ? ST_EOL_WAIT : ST_FETCH;
        end else if (is_field_end(fifo_tag)) begin
          irq_set = 1'b1;
          exp_d   = fifo_tag;
          state_d = ST_SKIP_FIELD;
        end else begin
          irq_set = 1'b1;
          state_d = eol_q ? ST_FETCH : ST_SKIP_LINE;
        end
      end
      ST_EOL_WAIT: if (fifo_fire) begin
        if (fifo_tag == TAG_EOL) begin
          state_d = ST_FETCH;
        end else if (is_field_end(fifo_tag)) begin
          irq_set = 1'b1;
          exp_d   = fifo_tag;
          state_d = ST_SKIP_FIELD;
        end else begin
          irq_set = 1'b1;
        end
      end
      ST_FIELD_WAIT: if (fifo_fire) begin
        if (fifo_tag == exp_q) state_d = ST_FETCH;
        else                   irq_set = 1'b1;
      end
      ST_SKIP_LINE: if (ins_fire) begin
        if (in_sync) begin
          exp_d   = in_tag;
          state_d = ST_FIELD_WAIT;
        end else if (in_eol) begin
          state_d = ST_FETCH;
        end
      end
      ST_SKIP_FIELD: if (ins_fire && in_sync && (in_tag == exp_q)) begin
        state_d = ST_FETCH;
      end
      default: state_d = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_FETCH;
      eol_q   <= 1'b0;
      exp_q   <= 2'b10;
    end else begin
      state_q <= state_d;
      eol_q   <= eol_d;
      exp_q   <= exp_d;
    end
  end

  resync_remain #(.CNT_W(CNT_W)) u_remain (
    .clk      (clk),
    .rst      (rst),
    .load     (cnt_load),
    .load_val (in_cnt),
    .dec      (cnt_dec),
    .last     (cnt_last)
  );

  resync_outreg #(.DATA_W(DATA_W)) u_out (
    .clk       (clk),
    .rst       (rst),
    .push      (push),
    .push_data (fifo_data),
    .out_ready (wr_ready),
    .out_valid (wr_valid),
    .out_data  (wr_data),
    .free      (out_free)
  );

  resync_irq u_irq (
    .clk  (clk),
    .rst  (rst),
    .set  (irq_set),
    .clr  (irq_clear),
    .flag (irq_resync)
  );
endmodule

// File: rtl/capstream_resync_sva.sv
module capstream_resync_sva #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              fifo_valid,
  input logic              fifo_ready,
  input logic [1:0]        fifo_tag,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [DATA_W-1:0] wr_data,
  input logic              irq_clear,
  input logic              irq_resync
);
  // R1: reset leaves the write port empty and the interrupt low
  a_r1_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> (!wr_valid && !irq_resync));

  // R2: a freshly loaded write comes from a data-tagged pop one cycle before
  a_r2_write_from_data: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && (!$past(wr_valid) || $past(wr_ready)))
      |-> $past(fifo_valid && fifo_ready && (fifo_tag == 2'b00)));

  // R8: the interrupt only falls after a clear pulse
  a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
    (irq_resync && !irq_clear) |=> irq_resync);

  // R9: a stalled write holds its word
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_data)));
endmodule

bind capstream_resync capstream_resync_sva #(.DATA_W(DATA_W)) u_sva (
  .clk        (clk),
  .rst        (rst),
  .fifo_valid (fifo_valid),
  .fifo_ready (fifo_ready),
  .fifo_tag   (fifo_tag),
  .wr_valid   (wr_valid),
  .wr_ready   (wr_ready),
  .wr_data    (wr_data),
  .irq_clear  (irq_clear),
  .irq_resync (irq_resync)
);

// File: tb/capstream_resync_tb_top.sv
module capstream_resync_tb_top;
  localparam int DW = 32;
  localparam int CW = 12;
  localparam int IW = CW + 5;
  localparam int NVEC = 7;
  // each row: {word count, stall on write port}
  localparam logic [12:0] VEC [NVEC] = '{
    {12'd1, 1'b0}, {12'd3, 1'b0}, {12'd0, 1'b0}, {12'd8, 1'b1},
    {12'd16, 1'b0}, {12'd5, 1'b1}, {12'd2, 1'b0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ins_valid = 1'b0, ins_ready;
  logic [IW-1:0] ins_word = '0;
  logic fifo_valid = 1'b0, fifo_ready;
  logic [DW-1:0] fifo_data = '0;
  logic [1:0] fifo_tag = '0;
  logic wr_valid, wr_ready = 1'b1;
  logic [DW-1:0] wr_data;
  logic irq_clear = 1'b0, irq_resync;

  always #5 clk = ~clk;

  capstream_resync #(.DATA_W(DW), .CNT_W(CW)) dut_i (
    .clk(clk), .rst(rst),
    .ins_valid(ins_valid), .ins_ready(ins_ready), .ins_word(ins_word),
    .fifo_valid(fifo_valid), .fifo_ready(fifo_ready),
    .fifo_data(fifo_data), .fifo_tag(fifo_tag),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .irq_clear(irq_clear), .irq_resync(irq_resync)
  );

  logic [IW-1:0] iq[$];
  logic [DW+1:0] fq[$];
  logic [DW-1:0] got[$];
  logic [DW-1:0] expq[$];
  int total = 0, fails = 0, cyc = 0, hold_err = 0;
  logic ins_fire = 1'b0, fifo_fire = 1'b0, stall = 1'b0;
  logic prev_stalled = 1'b0;
  logic [DW-1:0] prev_data = '0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      $display("FAIL watchdog: actual cycles=%0d expected < 150000", cyc);
      fails = fails + 1;
      total = total + 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  // instruction and FIFO drivers
  always @(negedge clk) begin
    if (ins_fire && iq.size() > 0) void'(iq.pop_front());
    if (fifo_fire && fq.size() > 0) void'(fq.pop_front());
    ins_valid = (iq.size() > 0);
    ins_word  = (iq.size() > 0) ? iq[0] : '0;
    fifo_valid = (fq.size() > 0);
    {fifo_tag, fifo_data} = (fq.size() > 0) ? fq[0] : '0;
    #1;
    ins_fire  = ins_valid && ins_ready && !rst;
    fifo_fire = fifo_valid && fifo_ready && !rst;
  end

  // write port sink and hold monitor
  always @(negedge clk) begin
    wr_ready = stall ? ((cyc % 3) != 0) : 1'b1;
    #1;
    if (prev_stalled && (!wr_valid || wr_data != prev_data)) hold_err = hold_err + 1;
    prev_stalled = wr_valid && !wr_ready;
    prev_data = wr_data;
    if (wr_valid && wr_ready && !rst) got.push_back(wr_data);
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    total = total + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put_w(input int cnt, input bit eol);
    iq.push_back({2'b00, CW'(cnt), eol, 2'b00});
  endtask
  task automatic put_sync(input logic [1:0] st);
    iq.push_back({2'b01, CW'(0), 1'b0, st});
  endtask
  task automatic put_d(input int n, input logic [DW-1:0] base, input bit keep);
    for (int i = 0; i < n; i++) begin
      fq.push_back({2'b00, base + DW'(i)});
      if (keep) expq.push_back(base + DW'(i));
    end
  endtask
  task automatic put_tag(input logic [1:0] t);
    fq.push_back({t, DW'(0)});
  endtask

  task automatic run_and_check(input string req, input bit exp_irq);
    int guard = 0;
    int bad = 0;
    while ((iq.size() > 0 || fq.size() > 0) && guard < 3000) begin
      @(negedge clk);
      guard++;
    end
    repeat (8) @(negedge clk);
    if (got.size() != expq.size()) bad = 1;
    else for (int i = 0; i < got.size(); i++) if (got[i] != expq[i]) bad = 1;
    chk(bad == 0, {req, " writes"}, 64'(got.size()), 64'(expq.size()));
    chk(irq_resync == exp_irq, {req, " irq"}, 64'(irq_resync), 64'(exp_irq));
    got.delete();
    expq.delete();
  endtask

  task automatic pulse_clear();
    @(negedge clk); irq_clear = 1'b1;
    @(negedge clk); irq_clear = 1'b0;
    chk(irq_resync == 1'b0, "R8 clear", 64'(irq_resync), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    #2;
    // R1: idle after reset
    chk(!wr_valid && !irq_resync && ins_ready && !fifo_ready, "R1 reset",
        {60'd0, wr_valid, irq_resync, ins_ready, fifo_ready}, 64'h2);

    // R2 / R7 / R9: matched lines from the table
    for (int k = 0; k < NVEC; k++) begin
      stall = VEC[k][0];
      put_w(int'(VEC[k][12:1]), 1'b1);
      put_d(int'(VEC[k][12:1]), 32'hA000_0000 + (k << 8), 1'b1);
      put_tag(2'b01);
      run_and_check("R2 line", 1'b0);
    end
    stall = 1'b0;
    chk(hold_err == 0, "R9 hold under stall", 64'(hold_err), 64'd0);

    // R3: short line, skip to the end-of-line instruction
    put_w(4, 1'b0); put_w(4, 1'b0); put_w(4, 1'b1);
    put_d(3, 32'hB000_0000, 1'b1); put_tag(2'b01);
    run_and_check("R3 short line", 1'b1);
    pulse_clear();
    put_w(2, 1'b1); put_d(2, 32'hB100_0000, 1'b1); put_tag(2'b01);
    run_and_check("R3 realigned", 1'b0);

    // R4: long line, extra words dropped
    put_w(2, 1'b1);
    put_d(2, 32'hC000_0000, 1'b1); put_d(3, 32'hC0FF_0000, 1'b0); put_tag(2'b01);
    run_and_check("R4 long line", 1'b1);
    // R8: stays set through a clean line
    put_w(1, 1'b1); put_d(1, 32'hC100_0000, 1'b1); put_tag(2'b01);
    run_and_check("R8 sticky", 1'b1);
    pulse_clear();

    // R5: short field, skip to matching odd sync
    put_w(2, 1'b1); put_w(2, 1'b1); put_w(2, 1'b1); put_sync(2'b10);
    put_d(2, 32'hD000_0000, 1'b1); put_tag(2'b01);
    put_d(1, 32'hD100_0000, 1'b1); put_tag(2'b11);
    run_and_check("R5 short field", 1'b1);
    pulse_clear();
    // R5: an even sync is skipped while an odd end is pending
    put_w(2, 1'b1); put_sync(2'b01); put_sync(2'b10);
    put_d(1, 32'hD200_0000, 1'b1); put_tag(2'b11);
    run_and_check("R5 skip wrong sync", 1'b1);
    pulse_clear();

    // R6: long field, drop until even end
    put_w(1, 1'b1); put_sync(2'b01);
    put_d(1, 32'hE000_0000, 1'b1); put_tag(2'b01);
    put_d(2, 32'hE0FF_0000, 1'b0); put_tag(2'b01); put_tag(2'b11); put_tag(2'b10);
    run_and_check("R6 long field", 1'b1);
    pulse_clear();

    // R7: matched field end
    put_w(2, 1'b1); put_sync(2'b10);
    put_d(2, 32'hF000_0000, 1'b1); put_tag(2'b01); put_tag(2'b11);
    run_and_check("R7 matched field", 1'b0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule